// File: doc/BRIEF.md
# Multiphase Trailing-Edge PWM Sequencer

This block drives two or three interleaved pulse-width-modulated lines from one free-running counter. The counter runs from 0 to P-1 and wraps, so P clock cycles form one switching cycle. Each channel owns a ramp that is this counter shifted by the channel's phase offset. A channel's pulse is cut off when its ramp returns to zero. The line is then held low for a forced interval of Q = ceil(P/4) cycles. After that interval it rises once its ramp reaches that channel's compare word, and it stays high until the next cut-off.

Channel 0 defines the cycle. The period, the phase-count select and the compare words are captured only while the block is disabled or at the channel-0 cut-off. A "sample now" strobe marks the end of each channel's forced low interval, which is the point where the phase current may be measured. Gate drivers and all analog work lie outside this block.

Top module: `mp_pwm_seq`

## Requirements
- R1: With two_phase_i = 0 (three-phase mode), channel k (k = 0, 1, 2) has its cut-off at counter value floor(k*P/3), so channel 1 ends P/3 cycles after channel 0 and channel 2 ends a further P/3 cycles later.
- R2: With two_phase_i = 1, channel 1 has its cut-off at counter value floor(P/2), and channel 2 keeps both pwm_o[2] and sample_o[2] low.
- R3: Enable is first seen high in cycle t = 0, with the counter at 0. In that cycle and every P cycles after it, channel 0 is cut off, and pwm_o[0] is low in the cycle that follows.
- R4: After a cut-off, a channel's line stays low for at least Q = ceil(P/4) cycles.
- R5: Bits cmp_i[k*CW +: CW] hold channel k's compare word C. Let M = max(Q, C), with M < P. The line rises one cycle after the cycle in which the ramp equals M, and it is high for exactly P - M cycles in each cycle. The smallest compare words therefore give the largest duty, which is P - Q.
- R6: A compare word C >= P keeps that channel's line low for the whole cycle.
- R7: A compare word changed part-way through a cycle takes effect only from the next channel-0 cut-off.
- R8: Once enable is low at a clock edge, all pwm_o and sample_o bits are low after that edge. The next enable restarts from t = 0, and each channel stays low until its own first cut-off.
- R9: sample_o[k] is high for exactly one cycle per cycle, when channel k's ramp equals Q counted from its cut-off. This starts from its first cut-off after enable.
- R10: A period_i value below 8 is used as P = 8.
- R11: After reset, with enable low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds outputs low and the counter at 0 |
| period_i | input | CW | Cycle length P in clocks (minimum 8) |
| two_phase_i | input | 1 | 1 selects two-phase timing, 0 three-phase |
| cmp_i | input | 3*CW | Per-channel compare words, channel k at bits [k*CW +: CW] |
| pwm_o | output | 3 | PWM line per channel |
| sample_o | output | 3 | One-cycle current-sample strobe per channel |

## Verification
The forced-low and sample-order properties rely on the quarter-cycle interval being at least two clocks. The period floor of 8 guarantees this, and the stimulus also uses periods below the floor to exercise it. The per-cycle reference model in the bench assumes that the period and the phase-count select stay fixed while the block is enabled. The random segments therefore change these only while enable is low. The one directed mid-run change alters a compare word, and during that run only channel 0 is compared cycle by cycle, because the other channels' ramps straddle the capture point.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int MAX_CH = 3;

  // forced-low length: a quarter cycle, rounded up so it is never shorter
  function automatic int quarter_ceil(int p);
    return (p + 3) / 4;
  endfunction

  // counter value at which channel ch terminates its pulse
  function automatic int phase_offset(int p, int ch, logic two);
    if (two) return (ch == 1) ? p / 2 : 0;
    return (p * ch) / 3;
  endfunction

  // channel ramp: master count shifted back by the offset, modulo p
  function automatic int ramp_of(int cnt, int off, int p);
    return (cnt >= off) ? cnt - off : cnt + p - off;
  endfunction
endpackage

// File: rtl/mp_ramp_timer.sv
module mp_ramp_timer import mp_pkg::*; #(
  parameter int CW   = 12,
  parameter int MINP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [CW-1:0]        period_i,
  input  logic                 two_i,
  input  logic [MAX_CH*CW-1:0] cmp_i,
  output logic [CW-1:0]        cnt_o,
  output logic [CW-1:0]        per_o,
  output logic                 two_o,
  output logic [MAX_CH*CW-1:0] cmp_o
);
  localparam logic [CW-1:0] FLOOR = CW'(MINP);

  logic [CW-1:0]        cnt_q, per_q;
  logic                 two_q;
  logic [MAX_CH*CW-1:0] cmp_q;
  logic [CW-1:0]        per_in_w;
  logic                 wrap_w;

  assign per_in_w = (period_i < FLOOR) ? FLOOR : period_i;
  assign wrap_w   = (cnt_q == per_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= FLOOR;
      two_q <= 1'b0;
      cmp_q <= '0;
    end else if (!enable || wrap_w) begin
      cnt_q <= '0;
      per_q <= per_in_w;
      two_q <= two_i;
      cmp_q <= cmp_i;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign two_o = two_q;
  assign cmp_o = cmp_q;

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q);
  p_period_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= FLOOR);
  p_hold_midcycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt_q != per_q - CW'(1)) |=> ($stable(cmp_q) && $stable(per_q) && $stable(two_q)));
endmodule

// File: rtl/mp_chan.sv
module mp_chan #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          active,
  input  logic [CW-1:0] ramp,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] qlen,
  output logic          pwm_o,
  output logic          smp_o
);
  logic          pwm_q, smp_q, started_q;
  logic [CW-1:0] hold_q;
  logic          term_w, armed_w, cross_w;

  assign term_w  = run && active && (ramp == '0);
  assign armed_w = started_q && (hold_q == '0);
  assign cross_w = (ramp >= cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0; smp_q <= 1'b0; started_q <= 1'b0; hold_q <= '0;
    end else if (!run || !active) begin
      pwm_q <= 1'b0; smp_q <= 1'b0; started_q <= 1'b0; hold_q <= '0;
    end else begin
      smp_q <= started_q && (hold_q == CW'(1)) && !term_w;
      if (term_w) begin
        pwm_q     <= 1'b0;
        started_q <= 1'b1;
        hold_q    <= qlen - CW'(1);
      end else begin
        if (hold_q != '0) hold_q <= hold_q - CW'(1);
        if (armed_w && cross_w) pwm_q <= 1'b1;
      end
    end
  end

  assign pwm_o = pwm_q;
  assign smp_o = smp_q;

  // independent trackers for the forced-low check
  logic [CW-1:0] low_run_q, qlat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '1;
      qlat_q    <= '0;
    end else begin
      if (pwm_q) low_run_q <= '0;
      else if (low_run_q != '1) low_run_q <= low_run_q + CW'(1);
      if (term_w) qlat_q <= qlen;
    end
  end

  p_term_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    term_w |=> !pwm_q);
  p_forced_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> (low_run_q >= qlat_q));
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !active) |=> (!pwm_q && !smp_q));
  p_sample_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_q |-> !pwm_q);
endmodule

// File: rtl/mp_pwm_seq.sv
module mp_pwm_seq import mp_pkg::*; #(
  parameter int CW   = 12,
  parameter int MINP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [CW-1:0]        period_i,
  input  logic                 two_phase_i,
  input  logic [MAX_CH*CW-1:0] cmp_i,
  output logic [MAX_CH-1:0]    pwm_o,
  output logic [MAX_CH-1:0]    sample_o
);
  logic [CW-1:0]        cnt_w, per_w, qlen_w;
  logic                 two_w;
  logic [MAX_CH*CW-1:0] cmp_w;

  mp_ramp_timer #(.CW(CW), .MINP(MINP)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .period_i(period_i), .two_i(two_phase_i), .cmp_i(cmp_i),
    .cnt_o(cnt_w), .per_o(per_w), .two_o(two_w), .cmp_o(cmp_w)
  );

  assign qlen_w = CW'(quarter_ceil(int'(per_w)));

  logic [CW-1:0] off_w  [MAX_CH];
  logic [CW-1:0] ramp_w [MAX_CH];
  logic          act_w  [MAX_CH];

  for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
    assign off_w[g]  = CW'(phase_offset(int'(per_w), g, two_w));
    assign ramp_w[g] = CW'(ramp_of(int'(cnt_w), int'(off_w[g]), int'(per_w)));
    if (g < MAX_CH - 1) begin : g_always
      assign act_w[g] = 1'b1;
    end else begin : g_moded
      assign act_w[g] = !two_w;
    end
    mp_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(enable), .active(act_w[g]),
      .ramp(ramp_w[g]), .cmp(cmp_w[g*CW +: CW]), .qlen(qlen_w),
      .pwm_o(pwm_o[g]), .smp_o(sample_o[g])
    );
  end

  p_third_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    two_w |=> (!pwm_o[MAX_CH-1] && !sample_o[MAX_CH-1]));
  p_one_term_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ramp_w[0] == '0, ramp_w[1] == '0}) <= 1);
endmodule

// File: tb/tb_mp_pwm_seq.sv
module tb_mp_pwm_seq;
  localparam int CW    = 12;
  localparam int CLK_P = 10;
  localparam int MINP  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable = 1'b0;
  logic            two = 1'b0;
  logic [CW-1:0]   period = CW'(16);
  logic [3*CW-1:0] cmp = '0;
  logic [2:0]      pwm, smp;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mp_pwm_seq #(.CW(CW), .MINP(MINP)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_i(period),
    .two_phase_i(two), .cmp_i(cmp), .pwm_o(pwm), .sample_o(smp)
  );

  function automatic int q_of(int p);
    return p / 4 + ((p % 4 != 0) ? 1 : 0);
  endfunction

  function automatic int off_of(int p, int ch, bit tw);
    int parts;
    parts = tw ? 2 : 3;
    return (ch * p) / parts;
  endfunction

  function automatic bit exp_pwm(int t, int ch, int p, bit tw, int c_old, int c_new, int ks);
    int tn, r, pi, c, m;
    if (tw && ch == 2) return 1'b0;
    tn = t - off_of(p, ch, tw);
    if (tn < 0) return 1'b0;
    r = tn % p;
    if (r == 0 && tn < p) return 1'b0;
    pi = (r == 0) ? tn / p - 1 : tn / p;
    c = (pi >= ks) ? c_new : c_old;
    m = (c > q_of(p)) ? c : q_of(p);
    if (m >= p) return 1'b0;
    return (r == 0) ? 1'b1 : (r > m);
  endfunction

  function automatic bit exp_smp(int t, int ch, int p, bit tw);
    int tn;
    if (tw && ch == 2) return 1'b0;
    tn = t - off_of(p, ch, tw);
    return (tn >= 0) && (tn % p == q_of(p));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // configure while disabled, then enable; a cmp change at cycle chg (ch0 only checked then)
  task automatic run_seg(int p_in, bit tw, int c0, int c1, int c2, int len,
                         int chg, int cn, string req);
    int p, ks;
    int cs[3];
    int bad_t[3];
    int bad_a[3];
    int bad_e[3];
    int sbad_t, sbad_a, sbad_e;
    p = (p_in < MINP) ? MINP : p_in;
    cs[0] = c0; cs[1] = c1; cs[2] = c2;
    ks = (chg >= 0) ? (chg + p) / p : 1 << 30;
    for (int k = 0; k < 3; k++) bad_t[k] = -1;
    for (int k = 0; k < 3; k++) begin bad_a[k] = 0; bad_e[k] = 0; end
    sbad_t = -1; sbad_a = 0; sbad_e = 0;
    @(negedge clk);
    enable = 1'b0;
    period = CW'(p_in);
    two = tw;
    cmp = {CW'(c2), CW'(c1), CW'(c0)};
    @(negedge clk);
    enable = 1'b1;                      // cycle t = 0
    for (int t = 1; t <= len; t++) begin
      @(negedge clk);
      for (int ch = 0; ch < 3; ch++) begin
        bit e, es;
        e  = exp_pwm(t, ch, p, tw, cs[ch], (ch == 0) ? cn : cs[ch], (ch == 0) ? ks : 1 << 30);
        es = exp_smp(t, ch, p, tw);
        if ((chg < 0 || ch == 0) && pwm[ch] !== e && bad_t[ch] < 0) begin
          bad_t[ch] = t; bad_a[ch] = int'(pwm[ch]); bad_e[ch] = int'(e);
        end
        if (smp[ch] !== es && sbad_t < 0) begin
          sbad_t = t; sbad_a = int'(smp[ch]); sbad_e = int'(es);
        end
      end
      if (t == chg) cmp[CW-1:0] = CW'(cn);
    end
    for (int ch = 0; ch < 3; ch++)
      if (chg < 0 || ch == 0)
        check(bad_t[ch] < 0, req, $sformatf("pwm ch%0d P=%0d first bad t=%0d", ch, p, bad_t[ch]),
              bad_a[ch], bad_e[ch]);
    check(sbad_t < 0, "R9", $sformatf("sample P=%0d first bad t=%0d", p, sbad_t), sbad_a, sbad_e);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    check(pwm == 3'b000, "R11", "pwm after reset", int'(pwm), 0);
    check(smp == 3'b000, "R11", "sample after reset", int'(smp), 0);

    // R1 R4 R5: three-phase, smallest compare -> duty P-Q
    run_seg(30, 1'b0, 0, 0, 0, 100, -1, 0, "R1 R4 R5");
    // R2: two-phase, third channel idle
    run_seg(24, 1'b1, 5, 12, 0, 90, -1, 0, "R2 R5");
    // R6: compare at or above period, and P-1 for one-cycle pulse
    run_seg(20, 1'b0, 20, 4095, 19, 80, -1, 0, "R6");
    // R10: period below floor
    run_seg(3, 1'b0, 2, 3, 6, 50, -1, 0, "R10");
    // R7: compare changed mid-cycle takes effect at next ch0 cut-off
    run_seg(40, 1'b0, 30, 30, 30, 200, 2 * 40 + 20, 12, "R7 R3");

    // R8: disable mid-run, outputs drop, restart from t=0
    run_seg(16, 1'b0, 4, 4, 4, 37, -1, 0, "R8");
    @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pwm == 3'b000 && smp == 3'b000, "R8", $sformatf("outputs while disabled i=%0d", i),
            int'({pwm, smp}), 0);
    end
    run_seg(16, 1'b0, 4, 4, 4, 60, -1, 0, "R8 R3");

    // random segments
    for (int i = 0; i < 24; i++) begin
      int p, c0, c1, c2;
      bit tw;
      p  = 8 + int'($urandom_range(0, 72));
      tw = 1'($urandom_range(0, 1));
      c0 = int'($urandom_range(0, p + 4));
      c1 = int'($urandom_range(0, p + 4));
      c2 = int'($urandom_range(0, p + 4));
      run_seg(p, tw, c0, c1, c2, 3 * p + 7, -1, 0, tw ? "R2 R3 R5" : "R1 R3 R5");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule